// File: doc/BRIEF.md
# VGA Register Image Replay Sequencer

This block restores a saved set of VGA controller registers into the display hardware. A stored image of the register bytes sits in a small RAM. After a start pulse, the block reads that RAM and issues a fixed series of byte-wide I/O accesses on an index/data port bus. Every access is a single handshake: the block holds its strobe until the target acknowledges.

The replay order is chosen so that the hardware is never left in an unsafe state. The miscellaneous output byte goes out first. The sequencer is held in synchronous reset with the screen blanked while its clocking register is rewritten, then released. The CRTC lock bit is cleared by a read-modify-write before the CRTC block is written. The graphics controller follows. The attribute controller comes last, and each of its index/data pairs is preceded by a status read that resets the port's flip-flop. A mode input limits the replay to the sequencer and graphics controller stages.

The register counts are parameters. NSEQ must be at least 2.

Top module: `vga_reg_replay`

## Requirements
- R1: With `seqGfxOnly` low, the first access writes image byte 0 to port 0x3C2. Image layout: byte 0 is the miscellaneous output value, sequencer register i is at 1+i, CRTC register i at 1+NSEQ+i, graphics register i at 1+NSEQ+NCRT+i, and attribute register i at 1+NSEQ+NCRT+NGFX+i. The image RAM returns data one cycle after it samples `imgAddr`.
- R2: The sequencer stage opens with the writes 0x3C4←0x00, 0x3C5←0x01, 0x3C4←0x01, then writes sequencer register 1, then closes with 0x3C4←0x00, 0x3C5←0x03.
- R3: The value written to sequencer register 1 is its image byte with bit 5 forced to 1.
- R4: After the closing write, sequencer registers 2 to NSEQ-1 are written in ascending order, each as the index to 0x3C4 followed by the image byte to 0x3C5.
- R5: With `seqGfxOnly` low, the block writes 0x11 to the CRTC index port, reads the CRTC data port, and writes back the value it read with bit 7 cleared.
- R6: With `seqGfxOnly` low, CRTC registers 0 to NCRT-1 are then written in ascending order as index/data pairs.
- R7: Graphics controller registers 0 to NGFX-1 are always written in ascending order as pairs to 0x3CE/0x3CF, after the CRTC stage.
- R8: With `seqGfxOnly` low, each attribute register i (ascending) is written as a status read, then a write of i to 0x3C0, then a write of its image byte to 0x3C0.
- R9: Bit 0 of image byte 0 selects the port set. When it is 1, CRTC is at 0x3D4/0x3D5 and status at 0x3DA. When it is 0, CRTC is at 0x3B4/0x3B5 and status at 0x3BA.
- R10: With `seqGfxOnly` high at start, only the sequencer and graphics stages run. There are no miscellaneous, CRTC or attribute accesses.
- R11: At most one of `ioWr` and `ioRd` is high. A strobe stays high, with address and write data unchanged, until `ioAck` is seen. Both strobes are low after reset.
- R12: A start pulse while a replay is in progress has no effect. The access count and the sequence stay as for a single replay.
- R13: `done` is high for exactly one cycle. That cycle directly follows the cycle in which the final access was acknowledged, and no strobe is active during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a replay (ignored while busy) |
| seqGfxOnly | input | 1 | Restrict replay to sequencer and graphics stages |
| imgAddr | output | IMG_AW | Image RAM read address |
| imgData | input | 8 | Image RAM read data, one cycle after address |
| ioAddr | output | 16 | I/O port address |
| ioWdata | output | 8 | I/O write data |
| ioWr | output | 1 | I/O write strobe, held until acknowledge |
| ioRd | output | 1 | I/O read strobe, held until acknowledge |
| ioRdata | input | 8 | I/O read data, valid with acknowledge |
| ioAck | input | 1 | Access acknowledge |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can coincide: a new start request, and the acknowledge that advances the running replay to its next step. The bench holds `start` high for twenty cycles in the middle of a full replay while the responder acknowledges with varying wait states, so start lands on acknowledge cycles as well as on waiting cycles. The result is judged from the port trace. The run must give exactly the access list of one replay, in order, and exactly one done pulse, timed one cycle after the last acknowledge. Colour, mono and restricted modes are each swept with different image contents and acknowledge delays.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

  // target of the current access
  typedef enum logic [3:0] {
    SEL_MISC, SEL_SEQI, SEL_SEQD, SEL_CRTI, SEL_CRTD,
    SEL_GFXI, SEL_GFXD, SEL_ATTR, SEL_STAT
  } ioSel_e;

  // where the write byte comes from
  typedef enum logic [2:0] {
    SRC_IDX, SRC_CONST, SRC_IMG, SRC_BLANK, SRC_UNPROT
  } dataSrc_e;

  // control -> datapath strobes
  typedef struct packed {
    ioSel_e     sel;
    dataSrc_e   src;
    logic [7:0] idx;
    logic [7:0] konst;
    logic       rd;
    logic       go;
    logic       grabMisc;
    logic       grabRd;
  } dpCtl_t;

  localparam logic [15:0] PORT_MISC_W = 16'h03C2;
  localparam logic [15:0] PORT_SEQ_I  = 16'h03C4;
  localparam logic [15:0] PORT_SEQ_D  = 16'h03C5;
  localparam logic [15:0] PORT_GFX_I  = 16'h03CE;
  localparam logic [15:0] PORT_GFX_D  = 16'h03CF;
  localparam logic [15:0] PORT_ATTR   = 16'h03C0;
  localparam logic [15:0] PORT_CRTI_C = 16'h03D4;
  localparam logic [15:0] PORT_CRTD_C = 16'h03D5;
  localparam logic [15:0] PORT_STAT_C = 16'h03DA;
  localparam logic [15:0] PORT_CRTI_M = 16'h03B4;
  localparam logic [15:0] PORT_CRTD_M = 16'h03B5;
  localparam logic [15:0] PORT_STAT_M = 16'h03BA;

  localparam logic [7:0] SEQ_HOLD      = 8'h01;
  localparam logic [7:0] SEQ_RUN       = 8'h03;
  localparam logic [7:0] SCREEN_OFF    = 8'h20;
  localparam logic [7:0] CRT_LOCK_IDX  = 8'h11;
  localparam logic [7:0] CRT_LOCK_MASK = 8'h7F;

endpackage

// File: rtl/vrr_ctrl.sv
module vrr_ctrl
  import vrr_pkg::*;
#(
  parameter int NSEQ = 5,
  parameter int NCRT = 25,
  parameter int NGFX = 9,
  parameter int NATT = 21
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   seqGfxOnly,
  input  logic   ioAck,
  output dpCtl_t ctl,
  output logic   done
);

  localparam int MAX_A = (NSEQ > NCRT) ? NSEQ : NCRT;
  localparam int MAX_B = (NGFX > NATT) ? NGFX : NATT;
  localparam int MAXN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_BUS, ST_DONE} state_e;
  typedef enum logic [2:0] {PH_MISC, PH_SRST, PH_SEQ, PH_UNP, PH_CRT, PH_GFX, PH_ATT} phase_e;

  state_e            st;
  phase_e            phase, nPhase;
  logic [2:0]        sub, nSub;
  logic [IDX_W-1:0]  idx, nIdx;
  logic              gfxOnlyQ, lastStep, advance;
  dpCtl_t            raw;

  // decode the current step into an access description
  always_comb begin
    raw       = '0;
    raw.idx   = 8'(idx);
    raw.go    = 1'b1;
    raw.sel   = SEL_SEQI;
    raw.src   = SRC_CONST;
    unique case (phase)
      PH_MISC: begin
        raw.sel = SEL_MISC;
        raw.src = SRC_IMG;
        raw.go  = !gfxOnlyQ;
      end
      PH_SRST: begin
        unique case (sub)
          3'd0:    begin raw.sel = SEL_SEQI; raw.konst = 8'h00; end
          3'd1:    begin raw.sel = SEL_SEQD; raw.konst = SEQ_HOLD; end
          3'd2:    begin raw.sel = SEL_SEQI; raw.konst = 8'h01; end
          3'd3:    begin raw.sel = SEL_SEQD; raw.src = SRC_BLANK; raw.idx = 8'h01; end
          3'd4:    begin raw.sel = SEL_SEQI; raw.konst = 8'h00; end
          default: begin raw.sel = SEL_SEQD; raw.konst = SEQ_RUN; end
        endcase
      end
      PH_SEQ: begin
        raw.sel = (sub == 3'd0) ? SEL_SEQI : SEL_SEQD;
        raw.src = (sub == 3'd0) ? SRC_IDX : SRC_IMG;
      end
      PH_UNP: begin
        unique case (sub)
          3'd0:    begin raw.sel = SEL_CRTI; raw.konst = CRT_LOCK_IDX; end
          3'd1:    begin raw.sel = SEL_CRTD; raw.rd = 1'b1; end
          default: begin raw.sel = SEL_CRTD; raw.src = SRC_UNPROT; end
        endcase
      end
      PH_CRT: begin
        raw.sel = (sub == 3'd0) ? SEL_CRTI : SEL_CRTD;
        raw.src = (sub == 3'd0) ? SRC_IDX : SRC_IMG;
      end
      PH_GFX: begin
        raw.sel = (sub == 3'd0) ? SEL_GFXI : SEL_GFXD;
        raw.src = (sub == 3'd0) ? SRC_IDX : SRC_IMG;
      end
      PH_ATT: begin
        unique case (sub)
          3'd0:    begin raw.sel = SEL_STAT; raw.rd = 1'b1; end
          3'd1:    begin raw.sel = SEL_ATTR; raw.src = SRC_IDX; end
          default: begin raw.sel = SEL_ATTR; raw.src = SRC_IMG; end
        endcase
      end
      default: ;
    endcase
  end

  // successor step
  always_comb begin
    nPhase   = phase;
    nSub     = sub + 3'd1;
    nIdx     = idx;
    lastStep = 1'b0;
    unique case (phase)
      PH_MISC: begin nPhase = PH_SRST; nSub = '0; end
      PH_SRST: if (sub == 3'd5) begin
        nSub = '0;
        if (NSEQ > 2) begin
          nPhase = PH_SEQ;
          nIdx   = IDX_W'(2);
        end else begin
          nPhase = gfxOnlyQ ? PH_GFX : PH_UNP;
          nIdx   = '0;
        end
      end
      PH_SEQ: if (sub != 3'd0) begin
        nSub = '0;
        if (idx == IDX_W'(NSEQ - 1)) begin
          nPhase = gfxOnlyQ ? PH_GFX : PH_UNP;
          nIdx   = '0;
        end else nIdx = idx + IDX_W'(1);
      end
      PH_UNP: if (sub == 3'd2) begin nPhase = PH_CRT; nSub = '0; nIdx = '0; end
      PH_CRT: if (sub != 3'd0) begin
        nSub = '0;
        if (idx == IDX_W'(NCRT - 1)) begin nPhase = PH_GFX; nIdx = '0; end
        else nIdx = idx + IDX_W'(1);
      end
      PH_GFX: if (sub != 3'd0) begin
        nSub = '0;
        if (idx == IDX_W'(NGFX - 1)) begin
          if (gfxOnlyQ) lastStep = 1'b1;
          else begin nPhase = PH_ATT; nIdx = '0; end
        end else nIdx = idx + IDX_W'(1);
      end
      PH_ATT: if (sub == 3'd2) begin
        nSub = '0;
        if (idx == IDX_W'(NATT - 1)) lastStep = 1'b1;
        else nIdx = idx + IDX_W'(1);
      end
      default: ;
    endcase
  end

  assign advance = (st == ST_BUS) && (ioAck || !raw.go);
  assign done    = (st == ST_DONE);

  always_comb begin
    ctl          = raw;
    ctl.go       = raw.go && (st == ST_BUS);
    ctl.grabMisc = advance && (phase == PH_MISC);
    ctl.grabRd   = advance && raw.rd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      phase    <= PH_MISC;
      sub      <= '0;
      idx      <= '0;
      gfxOnlyQ <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st       <= ST_FETCH;
          phase    <= PH_MISC;
          sub      <= '0;
          idx      <= '0;
          gfxOnlyQ <= seqGfxOnly;
        end
        ST_FETCH: st <= ST_BUS;
        ST_BUS: if (advance) begin
          st    <= lastStep ? ST_DONE : ST_FETCH;
          phase <= nPhase;
          sub   <= nSub;
          idx   <= nIdx;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vrr_dp.sv
module vrr_dp
  import vrr_pkg::*;
#(
  parameter int NSEQ   = 5,
  parameter int NCRT   = 25,
  parameter int NGFX   = 9,
  parameter int NATT   = 21,
  parameter int IMG_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        imgData,
  input  logic [7:0]        ioRdata,
  output logic [IMG_AW-1:0] imgAddr,
  output logic [15:0]       ioAddr,
  output logic [7:0]        ioWdata,
  output logic              ioWr,
  output logic              ioRd
);

  localparam int BASE_MISC = 0;
  localparam int BASE_SEQ  = 1;
  localparam int BASE_CRT  = BASE_SEQ + NSEQ;
  localparam int BASE_GFX  = BASE_CRT + NCRT;
  localparam int BASE_ATT  = BASE_GFX + NGFX;

  logic       colourQ;
  logic [7:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colourQ <= 1'b1;
      rdQ     <= '0;
    end else begin
      if (ctl.grabMisc) colourQ <= imgData[0];
      if (ctl.grabRd)   rdQ     <= ioRdata;
    end
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_MISC: imgAddr = IMG_AW'(BASE_MISC);
      SEL_SEQD: imgAddr = IMG_AW'(BASE_SEQ + int'(ctl.idx));
      SEL_CRTD: imgAddr = IMG_AW'(BASE_CRT + int'(ctl.idx));
      SEL_GFXD: imgAddr = IMG_AW'(BASE_GFX + int'(ctl.idx));
      SEL_ATTR: imgAddr = IMG_AW'(BASE_ATT + int'(ctl.idx));
      default:  imgAddr = '0;
    endcase
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_MISC: ioAddr = PORT_MISC_W;
      SEL_SEQI: ioAddr = PORT_SEQ_I;
      SEL_SEQD: ioAddr = PORT_SEQ_D;
      SEL_CRTI: ioAddr = colourQ ? PORT_CRTI_C : PORT_CRTI_M;
      SEL_CRTD: ioAddr = colourQ ? PORT_CRTD_C : PORT_CRTD_M;
      SEL_GFXI: ioAddr = PORT_GFX_I;
      SEL_GFXD: ioAddr = PORT_GFX_D;
      SEL_ATTR: ioAddr = PORT_ATTR;
      default:  ioAddr = colourQ ? PORT_STAT_C : PORT_STAT_M;
    endcase
  end

  always_comb begin
    unique case (ctl.src)
      SRC_IDX:    ioWdata = ctl.idx;
      SRC_IMG:    ioWdata = imgData;
      SRC_BLANK:  ioWdata = imgData | SCREEN_OFF;
      SRC_UNPROT: ioWdata = rdQ & CRT_LOCK_MASK;
      default:    ioWdata = ctl.konst;
    endcase
  end

  assign ioWr = ctl.go & ~ctl.rd;
  assign ioRd = ctl.go & ctl.rd;

endmodule

// File: rtl/vga_reg_replay.sv
module vga_reg_replay
  import vrr_pkg::*;
#(
  parameter int NSEQ = 5,
  parameter int NCRT = 25,
  parameter int NGFX = 9,
  parameter int NATT = 21,
  localparam int IMG_N  = 1 + NSEQ + NCRT + NGFX + NATT,
  localparam int IMG_AW = $clog2(IMG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              seqGfxOnly,
  output logic [IMG_AW-1:0] imgAddr,
  input  logic [7:0]        imgData,
  output logic [15:0]       ioAddr,
  output logic [7:0]        ioWdata,
  output logic              ioWr,
  output logic              ioRd,
  input  logic [7:0]        ioRdata,
  input  logic              ioAck,
  output logic              done
);

  dpCtl_t ctl;

  vrr_ctrl #(.NSEQ(NSEQ), .NCRT(NCRT), .NGFX(NGFX), .NATT(NATT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .seqGfxOnly(seqGfxOnly),
    .ioAck(ioAck), .ctl(ctl), .done(done)
  );

  vrr_dp #(.NSEQ(NSEQ), .NCRT(NCRT), .NGFX(NGFX), .NATT(NATT), .IMG_AW(IMG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .imgData(imgData), .ioRdata(ioRdata),
    .imgAddr(imgAddr), .ioAddr(ioAddr), .ioWdata(ioWdata), .ioWr(ioWr), .ioRd(ioRd)
  );

endmodule

// File: rtl/vrr_chk.sv
module vrr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ioWr,
  input logic        ioRd,
  input logic        ioAck,
  input logic        done,
  input logic [15:0] ioAddr,
  input logic [7:0]  ioWdata
);

  logic [7:0] lastSeqIdx;
  logic [1:0] sinceStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSeqIdx <= 8'hFF;
      sinceStat  <= 2'd2;
    end else begin
      if (ioWr && ioAck && ioAddr == 16'h03C4) lastSeqIdx <= ioWdata;
      if (ioRd && ioAck && (ioAddr == 16'h03DA || ioAddr == 16'h03BA)) sinceStat <= 2'd0;
      else if (ioWr && ioAck && ioAddr == 16'h03C0 && sinceStat != 2'd3) sinceStat <= sinceStat + 2'd1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN) !(ioWr && ioRd)); // R11
  AST_HOLD_WR: assert property (@(posedge clk) disable iff (!rstN)
    ioWr && !ioAck |=> ioWr && $stable(ioAddr) && $stable(ioWdata)); // R11
  AST_HOLD_RD: assert property (@(posedge clk) disable iff (!rstN)
    ioRd && !ioAck |=> ioRd && $stable(ioAddr)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R13
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN) done |-> !ioWr && !ioRd); // R13
  AST_SEQ1_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    ioWr && ioAddr == 16'h03C5 && lastSeqIdx == 8'h01 |-> ioWdata[5]); // R3
  AST_ATT_PRIMED: assert property (@(posedge clk) disable iff (!rstN)
    ioWr && ioAddr == 16'h03C0 |-> sinceStat < 2'd2); // R8
  AST_READ_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    ioRd |-> (ioAddr == 16'h03D5 || ioAddr == 16'h03B5 ||
              ioAddr == 16'h03DA || ioAddr == 16'h03BA)); // R5

endmodule

bind vga_reg_replay vrr_chk u_chk (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAck(ioAck),
  .done(done), .ioAddr(ioAddr), .ioWdata(ioWdata)
);

// File: tb/sim_vga_reg_replay.sv
module sim_vga_reg_replay;

  localparam int NSEQ   = 5;
  localparam int NCRT   = 25;
  localparam int NGFX   = 9;
  localparam int NATT   = 21;
  localparam int IMG_N  = 1 + NSEQ + NCRT + NGFX + NATT;
  localparam int IMG_AW = $clog2(IMG_N);
  localparam int LOGMAX = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN, start, seqGfxOnly, ioAck, ioWr, ioRd, done;
  logic [IMG_AW-1:0] imgAddr;
  logic [7:0]        imgData, ioWdata, ioRdata;
  logic [15:0]       ioAddr;

  vga_reg_replay u0 (
    .clk(clk), .rstN(rstN), .start(start), .seqGfxOnly(seqGfxOnly),
    .imgAddr(imgAddr), .imgData(imgData), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdata(ioRdata), .ioAck(ioAck), .done(done)
  );

  logic [7:0]  img [IMG_N];
  logic [15:0] expA [LOGMAX];
  logic [7:0]  expD [LOGMAX];
  bit          expR [LOGMAX];
  string       expTag [LOGMAX];
  logic [15:0] logA [LOGMAX];
  logic [7:0]  logD [LOGMAX];
  bit          logR [LOGMAX];
  int expN, accIdx, waitCnt, negCnt, doneCnt, doneNeg, lastAckNeg, dseed;
  int checks = 0;
  int fails  = 0;
  logic [7:0] rdVal;

  // image RAM, one cycle read latency
  initial begin
    imgData = '0;
    forever begin
      @(posedge clk);
      imgData <= (int'(imgAddr) < IMG_N) ? img[imgAddr] : 8'h00;
    end
  end

  // bus responder and monitor
  initial begin
    ioAck = 1'b0; ioRdata = '0;
    forever begin
      @(negedge clk);
      negCnt++;
      if (done) begin doneCnt++; doneNeg = negCnt; end
      if (ioWr || ioRd) begin
        if (waitCnt >= ((accIdx * dseed) >> 1) % 4) begin
          ioAck   = 1'b1;
          ioRdata = rdVal;
          if (accIdx < LOGMAX) begin
            logA[accIdx] = ioAddr; logD[accIdx] = ioWdata; logR[accIdx] = ioRd;
          end
          accIdx++;
          lastAckNeg = negCnt;
          waitCnt = 0;
        end else begin
          ioAck = 1'b0;
          waitCnt++;
        end
      end else ioAck = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [7:0] d, input bit r, input string tag);
    expA[expN] = a; expD[expN] = d; expR[expN] = r; expTag[expN] = tag;
    expN++;
  endtask

  task automatic build(input bit flag);
    bit colour = img[0][0];
    logic [15:0] ci = colour ? 16'h03D4 : 16'h03B4;
    logic [15:0] cd = colour ? 16'h03D5 : 16'h03B5;
    logic [15:0] st = colour ? 16'h03DA : 16'h03BA;
    expN = 0;
    if (!flag) push(16'h03C2, img[0], 0, "R1");
    push(16'h03C4, 8'h00, 0, "R2");
    push(16'h03C5, 8'h01, 0, "R2");
    push(16'h03C4, 8'h01, 0, "R2");
    push(16'h03C5, img[2] | 8'h20, 0, "R3");
    push(16'h03C4, 8'h00, 0, "R2");
    push(16'h03C5, 8'h03, 0, "R2");
    for (int i = 2; i < NSEQ; i++) begin
      push(16'h03C4, 8'(i), 0, "R4");
      push(16'h03C5, img[1 + i], 0, "R4");
    end
    if (!flag) begin
      push(ci, 8'h11, 0, "R5,R9");
      push(cd, 8'h00, 1, "R5,R9");
      push(cd, rdVal & 8'h7F, 0, "R5");
      for (int i = 0; i < NCRT; i++) begin
        push(ci, 8'(i), 0, "R6,R9");
        push(cd, img[1 + NSEQ + i], 0, "R6");
      end
    end
    for (int i = 0; i < NGFX; i++) begin
      push(16'h03CE, 8'(i), 0, "R7");
      push(16'h03CF, img[1 + NSEQ + NCRT + i], 0, "R7");
    end
    if (!flag) begin
      for (int i = 0; i < NATT; i++) begin
        push(st, 8'h00, 1, "R8,R9");
        push(16'h03C0, 8'(i), 0, "R8");
        push(16'h03C0, img[1 + NSEQ + NCRT + NGFX + i], 0, "R8");
      end
    end
  endtask

  task automatic doRun(input bit flag, input int seed, input bit colour, input int dly, input bit poke);
    int lim;
    for (int k = 0; k < IMG_N; k++) img[k] = 8'(k * seed + seed * seed);
    img[0][0] = colour;
    rdVal = 8'(8'hC3 ^ seed);
    build(flag);
    @(negedge clk);
    dseed = dly; accIdx = 0; waitCnt = 0; doneCnt = 0; doneNeg = -1; lastAckNeg = -9;
    start = 1'b1; seqGfxOnly = flag;
    @(negedge clk);
    start = 1'b0; seqGfxOnly = 1'b0;
    if (poke) begin
      while (accIdx < 40) @(negedge clk);
      start = 1'b1;
      repeat (20) @(negedge clk);
      start = 1'b0;
    end
    lim = 0;
    while (doneCnt == 0 && lim < 5000) begin @(negedge clk); lim++; end
    repeat (30) @(negedge clk);
    check(accIdx == expN, flag ? "R10" : (poke ? "R12" : "R1"), "access count", accIdx, expN);
    for (int i = 0; i < expN && i < accIdx && i < LOGMAX; i++)
      check(logA[i] == expA[i] && logR[i] == expR[i] && (expR[i] || logD[i] == expD[i]),
            expTag[i], $sformatf("access %0d {rd,addr,data}", i),
            {7'd0, logR[i], logA[i], logD[i]}, {7'd0, expR[i], expA[i], expD[i]});
    check(doneCnt == 1, poke ? "R12" : "R13", "done pulse count", doneCnt, 1);
    check(doneNeg == lastAckNeg + 1, "R13", "done cycle after last ack", doneNeg, lastAckNeg + 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; seqGfxOnly = 1'b0; dseed = 1; rdVal = '0;
    negCnt = 0; accIdx = 0; doneCnt = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!ioWr && !ioRd, "R11", "strobes after reset", {ioWr, ioRd}, 0);
    check(!done, "R13", "done after reset", done, 0);
    doRun(0, 37, 1'b1, 3, 0); // colour, full
    doRun(0, 91, 1'b0, 5, 0); // mono, full
    doRun(1, 53, 1'b1, 7, 0); // restricted, colour
    doRun(1, 19, 1'b0, 2, 0); // restricted, mono
    doRun(0, 11, 1'b1, 1, 1); // start held mid-run
    doRun(0, 77, 1'b0, 0, 1); // zero-wait acks, start mid-run
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule